// File: doc/BRIEF.md
# Compare-Clear Timer/Counter

An 8-bit up-counter with a programmable clock divider, a compare register and a single compare output. The counter advances only on divider ticks. In the compare-clear waveform mode the compare register is the wrap point: the count climbs to that value and returns to zero on the following tick. In the other waveform codes the counter runs through the full range and wraps at the maximum value. Each time the count equals the compare value on a tick, the block raises a sticky compare flag and updates a compare output level according to a 2-bit action code.

Software programs the block through a simple register write port and reads it through an address-selected read port. A nonzero action code hands the associated pin over to the timer. The block then flags the override and places the timer level on the pin value in place of the normal port value. The pin output-enable follows the direction input, whatever the override state.

Top module: `tmr_ctc_timer`

## Requirements
- R1: After reset every register reads 0, and the compare flag, the compare output level and the override indication are all 0.
- R2: The clock-select register (address 1, bits 1:0) picks the tick rate. Code 00 stops the counter and holds the divider at zero. Code 01 ticks every clock, code 10 every 8 clocks and code 11 every 64 clocks. After a start from stop, the first count change under code 10 comes 8 clocks after the write takes effect.
- R3: With waveform bits 1:0 of the control register (address 0) equal to 10, a tick taken while the count equals the compare value loads 0, so the count runs ... TOP-1, TOP, 0, 1.
- R4: With any other waveform code the count wraps from the maximum to 0, and a tick taken while the count equals the compare value still counts as a match.
- R5: A match sets the compare flag on the clock edge of that tick, and the flag stays set while no clear arrives.
- R6: A one-cycle pulse on flag_clr clears the flag. If a clear and a match fall in the same cycle, the flag ends up set.
- R7: On a match, the action code in control bits 7:6 updates the compare output level: 01 inverts it, 10 drives it low, 11 drives it high, and 00 leaves it unchanged.
- R8: cmp_ovr is 1 exactly when the action code is nonzero. pin_val then equals cmp_out; otherwise pin_val equals port_val. pin_oe always equals dir_out.
- R9: Control register reads return the action code in bits 7:6 and the waveform code in bits 1:0, with bits 5:2 reading 0 whatever was written to them. Address 2 reads the compare value and address 3 reads the count.
- R10: A write to the count (address 3) takes effect on the next edge and wins over a tick in the same cycle. The next tick after the write produces no match, so the flag and the output level are untouched, but the count still advances or clears as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write address: 0 control, 1 clock select, 2 compare, 3 count |
| reg_wdata | input | 8 | Write data |
| reg_raddr | input | 2 | Read address, same map as writes |
| reg_rdata | output | 8 | Read data for reg_raddr |
| flag_clr | input | 1 | Clears the compare flag when high at an edge |
| cmp_flag | output | 1 | Sticky compare flag |
| cmp_out | output | 1 | Compare output level |
| cmp_ovr | output | 1 | Timer owns the pin (nonzero action code) |
| port_val | input | 1 | Normal port value for the pin |
| dir_out | input | 1 | Pin direction, 1 = output |
| pin_val | output | 1 | Value presented to the pin |
| pin_oe | output | 1 | Pin output enable |

## Verification
Two situations are hard to reach from the ports. The first is a match suppressed by a count write. The second is a flag clear that lands in the very cycle of a match. The stimulus reaches the first by loading the count with the compare value while the counter is stopped and then starting it at one tick per clock, so that the suppressed tick is the first one and its timing is exact. For the second, the counter runs at the undivided rate from a known start cycle, and the clear pulse is placed on the clock of the third match, counted from that start.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // action taken on the compare output when a match occurs
   typedef enum logic [1:0] {
      OM_OFF    = 2'b00,
      OM_TOGGLE = 2'b01,
      OM_CLEAR  = 2'b10,
      OM_SET    = 2'b11
   } out_mode_e;

   // tick source selection
   typedef enum logic [1:0] {
      CS_STOP = 2'b00,
      CS_DIV1 = 2'b01,
      CS_DIVM = 2'b10,
      CS_DIVH = 2'b11
   } clk_sel_e;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_CLK  = 2'd1;
   localparam logic [1:0] ADDR_CMP  = 2'd2;
   localparam logic [1:0] ADDR_CNT  = 2'd3;

   // waveform code that makes the compare register the wrap point
   localparam logic [1:0] WGM_CTC = 2'b10;

   // control register field positions
   localparam int MODE_LSB = 6;
   localparam int WGM_LSB  = 0;
   localparam int CS_LSB   = 0;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
   import tmr_pkg::*;
#(
   parameter int MID_LOG2 = 3,
   parameter int HI_LOG2  = 6,
   parameter bit TAPPED   = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  clk_sel_e sel,
   output logic     tick
);

   localparam int PW = HI_LOG2;

   if (MID_LOG2 < 1 || HI_LOG2 <= MID_LOG2) begin : g_bad_div
      $error("tmr_prescaler: need 1 <= MID_LOG2 < HI_LOG2");
   end

   logic [PW-1:0] div_q;

   if (TAPPED) begin : g_tap
      // one free-running counter; both divided rates are taps on it
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            div_q <= '0;
         else if (sel == CS_STOP)
            div_q <= '0;
         else
            div_q <= div_q + 1'b1;
      end

      always_comb begin
         case (sel)
            CS_STOP: tick = 1'b0;
            CS_DIV1: tick = 1'b1;
            CS_DIVM: tick = &div_q[MID_LOG2-1:0];
            default: tick = &div_q;
         endcase
      end
   end else begin : g_lim
      // counter compared against a selected limit and restarted on reach
      localparam logic [PW-1:0] LIM_M = PW'((1 << MID_LOG2) - 1);
      logic [PW-1:0] lim;
      logic          at_lim;

      always_comb begin
         lim    = (sel == CS_DIVM) ? LIM_M : '1;
         at_lim = (div_q >= lim);
         case (sel)
            CS_STOP: tick = 1'b0;
            CS_DIV1: tick = 1'b1;
            default: tick = at_lim;
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            div_q <= '0;
         else if (sel == CS_STOP || sel == CS_DIV1 || at_lim)
            div_q <= '0;
         else
            div_q <= div_q + 1'b1;
      end
   end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         ctc,
   input  logic [W-1:0] top_val,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] cnt,
   output logic         match
);

   logic skip_q;
   logic at_top;

   always_comb begin
      at_top = (cnt == top_val);
      match  = tick && !load && !skip_q && at_top;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         skip_q <= 1'b0;
      end else if (load) begin
         cnt    <= load_val;
         skip_q <= 1'b1;
      end else if (tick) begin
         skip_q <= 1'b0;
         cnt    <= (ctc && at_top) ? '0 : cnt + 1'b1;
      end
   end

endmodule

// File: rtl/tmr_cmp_out.sv
module tmr_cmp_out
   import tmr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      match,
   input  out_mode_e mode,
   input  logic      flag_clr,
   input  logic      port_val,
   input  logic      dir_out,
   output logic      flag,
   output logic      level,
   output logic      ovr,
   output logic      pin_val,
   output logic      pin_oe
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= 1'b0;
      else if (match)
         flag <= 1'b1;
      else if (flag_clr)
         flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= 1'b0;
      end else if (match) begin
         case (mode)
            OM_TOGGLE: level <= ~level;
            OM_CLEAR:  level <= 1'b0;
            OM_SET:    level <= 1'b1;
            default:   level <= level;
         endcase
      end
   end

   always_comb begin
      ovr     = (mode != OM_OFF);
      pin_val = ovr ? level : port_val;
      pin_oe  = dir_out;
   end

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [1:0]   waddr,
   input  logic [W-1:0] wdata,
   input  logic [1:0]   raddr,
   input  logic [W-1:0] cnt_in,
   output out_mode_e    mode,
   output logic [1:0]   wgm,
   output clk_sel_e     cs,
   output logic [W-1:0] cmp,
   output logic         cnt_wr,
   output logic [W-1:0] rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= OM_OFF;
         wgm  <= '0;
         cs   <= CS_STOP;
         cmp  <= '0;
      end else if (we) begin
         case (waddr)
            ADDR_CTRL: begin
               mode <= out_mode_e'(wdata[MODE_LSB +: 2]);
               wgm  <= wdata[WGM_LSB +: 2];
            end
            ADDR_CLK: cs  <= clk_sel_e'(wdata[CS_LSB +: 2]);
            ADDR_CMP: cmp <= wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      cnt_wr = we && (waddr == ADDR_CNT);
      rdata  = '0;
      case (raddr)
         ADDR_CTRL: begin
            rdata[MODE_LSB +: 2] = mode;
            rdata[WGM_LSB +: 2]  = wgm;
         end
         ADDR_CLK: rdata[CS_LSB +: 2] = cs;
         ADDR_CMP: rdata = cmp;
         default:  rdata = cnt_in;
      endcase
   end

endmodule

// File: rtl/tmr_ctc_timer.sv
module tmr_ctc_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W        = 8,
   parameter int PRE_MID_LOG2 = 3,
   parameter int PRE_HI_LOG2  = 6,
   parameter bit PRE_TAPPED   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [1:0]       reg_waddr,
   input  logic [CNT_W-1:0] reg_wdata,
   input  logic [1:0]       reg_raddr,
   output logic [CNT_W-1:0] reg_rdata,
   input  logic             flag_clr,
   output logic             cmp_flag,
   output logic             cmp_out,
   output logic             cmp_ovr,
   input  logic             port_val,
   input  logic             dir_out,
   output logic             pin_val,
   output logic             pin_oe
);

   if (CNT_W < 8) begin : g_bad_width
      $error("tmr_ctc_timer: CNT_W must be at least 8 to hold the control fields");
   end

   out_mode_e        mode_q;
   clk_sel_e         cs_q;
   logic [1:0]       wgm_q;
   logic [CNT_W-1:0] cmp_q;
   logic [CNT_W-1:0] cnt_q;
   logic             cnt_wr;
   logic             tick;
   logic             match;
   logic             ctc;

   assign ctc = (wgm_q == WGM_CTC);

   tmr_regs #(.W(CNT_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (reg_we),
      .waddr  (reg_waddr),
      .wdata  (reg_wdata),
      .raddr  (reg_raddr),
      .cnt_in (cnt_q),
      .mode   (mode_q),
      .wgm    (wgm_q),
      .cs     (cs_q),
      .cmp    (cmp_q),
      .cnt_wr (cnt_wr),
      .rdata  (reg_rdata)
   );

   tmr_prescaler #(
      .MID_LOG2 (PRE_MID_LOG2),
      .HI_LOG2  (PRE_HI_LOG2),
      .TAPPED   (PRE_TAPPED)
   ) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (cs_q),
      .tick  (tick)
   );

   tmr_counter #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .ctc      (ctc),
      .top_val  (cmp_q),
      .load     (cnt_wr),
      .load_val (reg_wdata),
      .cnt      (cnt_q),
      .match    (match)
   );

   tmr_cmp_out u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .match    (match),
      .mode     (mode_q),
      .flag_clr (flag_clr),
      .port_val (port_val),
      .dir_out  (dir_out),
      .flag     (cmp_flag),
      .level    (cmp_out),
      .ovr      (cmp_ovr),
      .pin_val  (pin_val),
      .pin_oe   (pin_oe)
   );

endmodule

// File: rtl/tmr_ctc_timer_chk.sv
module tmr_ctc_timer_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             match,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] cmp,
   input logic [1:0]       wgm,
   input logic [1:0]       mode,
   input logic [1:0]       cs,
   input logic             reg_we,
   input logic [1:0]       reg_waddr,
   input logic [CNT_W-1:0] reg_wdata,
   input logic             cmp_flag,
   input logic             cmp_out,
   input logic             flag_clr
);

   // R2
   stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs == 2'b00 && !(reg_we && reg_waddr == 2'd3)) |=> $stable(cnt));

   // R3
   ctc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && wgm == 2'b10 && cnt == cmp && !(reg_we && reg_waddr == 2'd3)) |=> (cnt == '0));

   // R5
   flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmp_flag) |-> $past(match));

   // R6
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_flag && !flag_clr) |=> cmp_flag);

   // R7
   set_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match && mode == 2'b11) |=> cmp_out);

   // R7
   clear_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match && mode == 2'b10) |=> !cmp_out);

   // R10
   cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_waddr == 2'd3) |=> (cnt == $past(reg_wdata)));

endmodule

bind tmr_ctc_timer tmr_ctc_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .match     (match),
   .cnt       (cnt_q),
   .cmp       (cmp_q),
   .wgm       (wgm_q),
   .mode      (mode_q),
   .cs        (cs_q),
   .reg_we    (reg_we),
   .reg_waddr (reg_waddr),
   .reg_wdata (reg_wdata),
   .cmp_flag  (cmp_flag),
   .cmp_out   (cmp_out),
   .flag_clr  (flag_clr)
);

// File: tb/tmr_ctc_timer_test.sv
module tmr_ctc_timer_test;

   localparam int W = 8;

   localparam int K_FLAG = 1;
   localparam int K_OUT  = 2;
   localparam int K_OVR  = 3;
   localparam int K_PIN  = 4;
   localparam int K_OE   = 5;
   localparam int K_RD0  = 10;
   localparam int K_CNT  = 13;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_we = 1'b0;
   logic [1:0]   reg_waddr = '0;
   logic [W-1:0] reg_wdata = '0;
   logic [1:0]   reg_raddr = '0;
   logic [W-1:0] reg_rdata;
   logic         flag_clr = 1'b0;
   logic         cmp_flag, cmp_out, cmp_ovr, pin_val, pin_oe;
   logic         port_val = 1'b1;
   logic         dir_out = 1'b0;

   always #2 clk = ~clk;

   tmr_ctc_timer uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
      .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .flag_clr(flag_clr), .cmp_flag(cmp_flag), .cmp_out(cmp_out),
      .cmp_ovr(cmp_ovr), .port_val(port_val), .dir_out(dir_out),
      .pin_val(pin_val), .pin_oe(pin_oe)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int    when;
      int    kind;
      int    exp;
      string req;
   } item_t;

   item_t sb[$];
   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;

   function automatic int observe(int kind);
      case (kind)
         K_FLAG:  return int'(cmp_flag);
         K_OUT:   return int'(cmp_out);
         K_OVR:   return int'(cmp_ovr);
         K_PIN:   return int'(pin_val);
         K_OE:    return int'(pin_oe);
         default: return int'(reg_rdata);
      endcase
   endfunction

   task automatic expect_at(input int when, input int kind, input int val, input string req);
      item_t it;
      it.when = when; it.kind = kind; it.exp = val; it.req = req;
      sb.push_back(it);
   endtask

   // monitor: samples away from the active edge and retires due items
   initial begin
      forever begin
         @(negedge clk);
         #1;
         for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].when <= cyc) begin
               int got;
               n_chk++;
               got = observe(sb[i].kind);
               if (sb[i].when < cyc) begin
                  n_fail++;
                  $display("FAIL %s kind %0d missed cycle %0d: got %0h expected %0h",
                           sb[i].req, sb[i].kind, sb[i].when, got, sb[i].exp);
               end else if (sb[i].kind >= K_RD0 && int'(reg_raddr) != sb[i].kind - K_RD0) begin
                  n_fail++;
                  $display("FAIL %s read address %0d at cycle %0d: got %0h expected %0h",
                           sb[i].req, reg_raddr, cyc, got, sb[i].exp);
               end else if (got != sb[i].exp) begin
                  n_fail++;
                  $display("FAIL %s kind %0d at cycle %0d: got %0h expected %0h",
                           sb[i].req, sb[i].kind, cyc, got, sb[i].exp);
               end
               sb.delete(i);
            end
         end
      end
   end

   // driver tasks, all entered on a falling edge
   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic wait_to(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic clr_pulse();
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
   endtask

   initial begin
      int t;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      expect_at(cyc, K_FLAG, 0, "R1");
      expect_at(cyc, K_OUT, 0, "R1");
      expect_at(cyc, K_OVR, 0, "R1");
      expect_at(cyc, K_PIN, 1, "R8");
      expect_at(cyc, K_OE, 0, "R8");
      for (int a = 0; a < 4; a++) begin
         reg_raddr = 2'(a);
         expect_at(cyc, K_RD0 + a, 0, "R1");
         @(negedge clk);
      end

      // compare-clear with toggle, one tick per clock
      reg_raddr = 2'd3;
      wr(2'd2, 8'd3);
      wr(2'd0, 8'h42);
      expect_at(cyc, K_OVR, 1, "R8");
      wr(2'd1, 8'h01);
      t = cyc;
      expect_at(t, K_CNT, 0, "R2");
      expect_at(t + 1, K_CNT, 1, "R2");
      expect_at(t + 3, K_CNT, 3, "R3");
      expect_at(t + 4, K_CNT, 0, "R3");
      expect_at(t + 5, K_CNT, 1, "R3");
      expect_at(t + 3, K_FLAG, 0, "R5");
      expect_at(t + 4, K_FLAG, 1, "R5");
      expect_at(t + 7, K_FLAG, 1, "R5");
      expect_at(t + 3, K_OUT, 0, "R7");
      expect_at(t + 4, K_OUT, 1, "R7");
      expect_at(t + 8, K_OUT, 0, "R7");
      expect_at(t + 10, K_FLAG, 0, "R6");
      expect_at(t + 11, K_FLAG, 0, "R6");
      expect_at(t + 12, K_FLAG, 1, "R6");
      expect_at(t + 16, K_CNT, 2, "R2");
      wait_to(t + 9);
      clr_pulse();
      wait_to(t + 11);
      clr_pulse();
      wait_to(t + 13);
      wr(2'd1, 8'h00);
      wait_to(t + 17);

      // clear-on-match action and pin ownership
      port_val = 1'b0;
      dir_out  = 1'b1;
      clr_pulse();
      wr(2'd0, 8'h82);
      expect_at(cyc, K_PIN, 1, "R8");
      expect_at(cyc, K_OE, 1, "R8");
      expect_at(cyc, K_FLAG, 0, "R6");
      @(negedge clk);
      dir_out = 1'b0;
      expect_at(cyc, K_OE, 0, "R8");
      @(negedge clk);
      dir_out = 1'b1;
      wr(2'd1, 8'h01);
      t = cyc;
      expect_at(t + 1, K_OUT, 1, "R7");
      expect_at(t + 2, K_OUT, 0, "R7");
      expect_at(t + 2, K_FLAG, 1, "R5");
      expect_at(t + 2, K_CNT, 0, "R3");
      expect_at(t + 4, K_CNT, 1, "R2");
      expect_at(t + 4, K_OUT, 0, "R7");
      wait_to(t + 2);
      wr(2'd1, 8'h00);
      wait_to(t + 5);

      // set-on-match action
      wr(2'd0, 8'hC2);
      wr(2'd1, 8'h01);
      t = cyc;
      expect_at(t + 2, K_OUT, 0, "R7");
      expect_at(t + 3, K_OUT, 1, "R7");
      wait_to(t + 3);
      wr(2'd1, 8'h00);

      // disconnected: port value passes, match leaves the level alone
      clr_pulse();
      wr(2'd0, 8'h02);
      expect_at(cyc, K_OVR, 0, "R8");
      expect_at(cyc, K_PIN, 0, "R8");
      expect_at(cyc, K_OUT, 1, "R7");
      wr(2'd1, 8'h01);
      t = cyc;
      expect_at(t + 3, K_FLAG, 1, "R5");
      expect_at(t + 4, K_OUT, 1, "R7");
      expect_at(t + 3, K_PIN, 0, "R8");
      wait_to(t + 4);
      wr(2'd1, 8'h00);

      // count write: immediate, suppresses the next match, beats a tick
      clr_pulse();
      wr(2'd0, 8'h42);
      wr(2'd3, 8'd3);
      expect_at(cyc, K_CNT, 3, "R10");
      wr(2'd1, 8'h01);
      t = cyc;
      expect_at(t + 1, K_CNT, 0, "R10");
      expect_at(t + 1, K_FLAG, 0, "R10");
      expect_at(t + 1, K_OUT, 1, "R10");
      expect_at(t + 5, K_FLAG, 1, "R10");
      expect_at(t + 5, K_OUT, 0, "R10");
      expect_at(t + 6, K_CNT, 8'h10, "R10");
      expect_at(t + 7, K_CNT, 8'h11, "R10");
      wait_to(t + 5);
      wr(2'd3, 8'h10);
      wait_to(t + 7);
      wr(2'd1, 8'h00);

      // free-running wrap with the divide-by-8 rate
      clr_pulse();
      wr(2'd0, 8'h00);
      wr(2'd3, 8'hFE);
      wr(2'd1, 8'h02);
      t = cyc;
      expect_at(t + 7, K_CNT, 8'hFE, "R2");
      expect_at(t + 8, K_CNT, 8'hFF, "R2");
      expect_at(t + 16, K_CNT, 8'h00, "R4");
      expect_at(t + 47, K_CNT, 8'h03, "R4");
      expect_at(t + 47, K_FLAG, 0, "R4");
      expect_at(t + 48, K_FLAG, 1, "R4");
      expect_at(t + 48, K_CNT, 8'h04, "R4");
      wait_to(t + 48);
      wr(2'd1, 8'h00);

      // readback of fields and reserved bits
      wr(2'd0, 8'hFF);
      reg_raddr = 2'd0;
      expect_at(cyc, K_RD0, 8'hC3, "R9");
      @(negedge clk);
      reg_raddr = 2'd2;
      expect_at(cyc, K_RD0 + 2, 8'd3, "R9");
      @(negedge clk);
      wr(2'd1, 8'hFF);
      reg_raddr = 2'd1;
      expect_at(cyc, K_RD0 + 1, 8'd3, "R9");
      @(negedge clk);
      wr(2'd1, 8'h00);

      while (sb.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run hung, got %0d pending expected 0", sb.size());
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule